// File: doc/BRIEF.md
# Interrupt Cycle Sequencer

This block is the interrupt control for a small accumulator machine. A free-running step counter produces one-hot timing steps. Between instruction fetches, when no early step is active, the block watches two device-ready flags. It acts on them only while the interrupt-enable bit is on. When a request is pending, it sets an interrupt-cycle flip-flop. That flip-flop gates off the normal fetch steps and takes over the next three steps.

In those three steps the block first copies the program counter into a temporary register and points the address register at word 0. It then writes the saved value into memory word 0 and zeroes the program counter. Finally it steps the program counter to 1, so execution resumes at the service entry. In the same final step it turns off interrupts, drops the flip-flop and restarts the step counter. The service routine returns through an indirect branch via word 0. That only works if word 0 holds the old program counter exactly.

The surrounding instruction logic controls three things through dedicated inputs: the enable bit (set or clear), program counter loads, and the end-of-instruction counter clear.

Top module: `intr_cycle_seq`

## Requirements
- R1: While rst_ni is low, the interrupt flip-flop, the enable bit, the step counter, PC, AR and TR are all 0. Right after release, t_o is 3'b001 (bit k of t_o is step Tk).
- R2: The step counter advances by one on every clock, so t_o goes 001, 010, 100 and then 000 until the counter wraps. A high sc_clr_i returns it to T0 (t_o = 001) on the next clock.
- R3: At a clock edge, the interrupt flip-flop becomes 1 only if three conditions hold together: the enable bit is 1, fgi_i or fgo_i is 1, and t_o is 000. While the enable bit is 0 it never becomes 1.
- R4: In the step with r_o=1 and T0 active, AR is loaded with 0 and TR with the current PC.
- R5: In the step with r_o=1 and T1 active, mem_we_o is high for exactly that one clock, with mem_addr_o = AR = 0 and mem_wdata_o = TR zero-extended. At the end of that step PC becomes 0.
- R6: In the step with r_o=1 and T2 active, PC becomes 1. At the end of that step the enable bit, r_o and the step counter are cleared. Flags held high afterwards do not set r_o again until the enable bit is set.
- R7: ion_i sets the enable bit and iof_i clears it. If both are high, it ends up 0. A clear from the end of the interrupt cycle also wins over ion_i.
- R8: pc_ld_i loads pc_d_i into PC only while r_o is 0. While r_o is 1 the load is ignored.
- R9: fetch_o[k] is t_o[k] gated by r_o being 0, so all fetch steps are 000 during the interrupt cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ion_i | input | 1 | Instruction request to set the enable bit |
| iof_i | input | 1 | Instruction request to clear the enable bit |
| fgi_i | input | 1 | Input device ready flag |
| fgo_i | input | 1 | Output device ready flag |
| sc_clr_i | input | 1 | End-of-instruction step counter clear |
| pc_ld_i | input | 1 | Load PC from pc_d_i (normal execution path) |
| pc_d_i | input | ADDR_W | PC load value |
| t_o | output | N_STEPS | One-hot timing steps T0..T2 |
| fetch_o | output | N_STEPS | Fetch/decode steps qualified by r_o low |
| r_o | output | 1 | Interrupt-cycle flip-flop |
| ien_o | output | 1 | Interrupt enable bit |
| pc_o | output | ADDR_W | Program counter |
| ar_o | output | ADDR_W | Address register |
| tr_o | output | ADDR_W | Temporary register |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | DATA_W | Memory write data |

## Verification
The assertions assume that the flags and control inputs change only between clock edges. They also assume that sc_clr_i is never raised while r_o is high and T0 to T2 are running. In that window a counter clear would restart the save sequence, and the step properties would no longer describe the intended cycle. The stimulus drives every input on the falling edge. It pulses sc_clr_i only at the start of an instruction or while r_o waits for T0. It also keeps flags asserted across the interrupt cycle, to show that a disabled block ignores them.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  localparam int unsigned N_STEPS = 3;

  typedef struct packed {
    logic save;   // R.T0
    logic wr;     // R.T1
    logic fin;    // R.T2
  } icyc_ctl_t;
endpackage

// File: rtl/intr_seq_cnt.sv
module intr_seq_cnt #(
  parameter int unsigned SC_W    = 3,
  parameter int unsigned N_STEPS = intr_seq_pkg::N_STEPS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  output logic [N_STEPS-1:0] t_o
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sc_q <= '0;
    else if (clr_i) sc_q <= '0;
    else            sc_q <= sc_q + SC_W'(1);
  end

  for (genvar k = 0; k < N_STEPS; k++) begin : g_dec
    assign t_o[k] = (sc_q == SC_W'(k));
  end

  AST_T_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(t_o)); // R2
  AST_SC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> t_o[0]); // R2
  AST_SC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_o[0] && !clr_i) |=> t_o[1]); // R2
endmodule

// File: rtl/intr_ctrl_ff.sv
module intr_ctrl_ff
  import intr_seq_pkg::*;
#(
  parameter int unsigned N_STEPS = intr_seq_pkg::N_STEPS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ion_i,
  input  logic               iof_i,
  input  logic               fgi_i,
  input  logic               fgo_i,
  input  logic [N_STEPS-1:0] t_i,
  output logic               r_o,
  output logic               ien_o,
  output logic               sc_clr_o,
  output logic [N_STEPS-1:0] fetch_o,
  output icyc_ctl_t          ctl_o
);
  logic r_q, ien_q;
  logic r_set, ien_clr;

  assign r_set   = ien_q & (fgi_i | fgo_i) & ~(|t_i);
  assign ctl_o   = '{save: r_q & t_i[0], wr: r_q & t_i[1], fin: r_q & t_i[2]};
  assign ien_clr = iof_i | ctl_o.fin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        r_q <= 1'b0;
    else if (ctl_o.fin) r_q <= 1'b0;
    else if (r_set)     r_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ien_q <= 1'b0;
    else if (ien_clr) ien_q <= 1'b0;
    else if (ion_i)   ien_q <= 1'b1;
  end

  for (genvar k = 0; k < N_STEPS; k++) begin : g_fetch
    assign fetch_o[k] = t_i[k] & ~r_q;
  end

  assign r_o      = r_q;
  assign ien_o    = ien_q;
  assign sc_clr_o = ctl_o.fin;

  AST_R_NEEDS_IEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(r_q) |-> $past(ien_q) && $past(fgi_i || fgo_i)); // R3
  AST_R_OUTSIDE_T: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(r_q) |-> $past(t_i) == '0); // R3
  AST_CYCLE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_q && t_i[2]) |=> !r_q && !ien_q); // R6
  AST_IOF_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iof_i |=> !ien_q); // R7
  AST_FETCH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_q |-> fetch_o == '0); // R9
endmodule

// File: rtl/intr_dp.sv
module intr_dp
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              r_i,
  input  icyc_ctl_t         ctl_i,
  input  logic              pc_ld_i,
  input  logic [ADDR_W-1:0] pc_d_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [ADDR_W-1:0] tr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [ADDR_W-1:0] pc_q, ar_q, tr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_q <= '0;
      tr_q <= '0;
    end else if (ctl_i.save) begin
      ar_q <= '0;
      tr_q <= pc_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pc_q <= '0;
    else if (ctl_i.wr)          pc_q <= '0;
    else if (ctl_i.fin)         pc_q <= pc_q + ADDR_W'(1);
    else if (pc_ld_i && !r_i)   pc_q <= pc_d_i;
  end

  assign pc_o        = pc_q;
  assign ar_o        = ar_q;
  assign tr_o        = tr_q;
  assign mem_we_o    = ctl_i.wr;
  assign mem_addr_o  = ar_q;
  assign mem_wdata_o = DATA_W'(tr_q);

  AST_SAVE_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.save |=> ar_q == '0 && tr_q == $past(pc_q)); // R4
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R5
  AST_PC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.wr |=> pc_q == '0); // R5
  AST_PC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.fin |=> pc_q == ADDR_W'(1)); // R6
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_i && !ctl_i.wr && !ctl_i.fin) |=> pc_q == $past(pc_q)); // R8
endmodule

// File: rtl/intr_cycle_seq.sv
module intr_cycle_seq
  import intr_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SC_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ion_i,
  input  logic               iof_i,
  input  logic               fgi_i,
  input  logic               fgo_i,
  input  logic               sc_clr_i,
  input  logic               pc_ld_i,
  input  logic [ADDR_W-1:0]  pc_d_i,
  output logic [N_STEPS-1:0] t_o,
  output logic [N_STEPS-1:0] fetch_o,
  output logic               r_o,
  output logic               ien_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [ADDR_W-1:0]  ar_o,
  output logic [ADDR_W-1:0]  tr_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o
);
  logic      sc_clr_int;
  icyc_ctl_t ctl;
  logic [N_STEPS-1:0] t;

  intr_seq_cnt #(.SC_W(SC_W), .N_STEPS(N_STEPS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sc_clr_i | sc_clr_int),
    .t_o   (t)
  );

  intr_ctrl_ff #(.N_STEPS(N_STEPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ion_i   (ion_i),
    .iof_i   (iof_i),
    .fgi_i   (fgi_i),
    .fgo_i   (fgo_i),
    .t_i     (t),
    .r_o     (r_o),
    .ien_o   (ien_o),
    .sc_clr_o(sc_clr_int),
    .fetch_o (fetch_o),
    .ctl_o   (ctl)
  );

  intr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .r_i        (r_o),
    .ctl_i      (ctl),
    .pc_ld_i    (pc_ld_i),
    .pc_d_i     (pc_d_i),
    .pc_o       (pc_o),
    .ar_o       (ar_o),
    .tr_o       (tr_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  assign t_o = t;

  AST_RESET_STATE: assert property (@(posedge clk_i)
    !rst_ni |-> !r_o && !ien_o && pc_o == '0 && ar_o == '0 && tr_o == '0); // R1
endmodule

// File: tb/intr_cycle_seq_tb.sv
module intr_cycle_seq_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NV = 8;
  // {pc[11:0], fgi, fgo, ien, taken}
  localparam logic [15:0] VEC [NV] = '{
    {12'h123, 1'b1, 1'b0, 1'b1, 1'b1},
    {12'hABC, 1'b0, 1'b1, 1'b1, 1'b1},
    {12'hFFF, 1'b1, 1'b1, 1'b1, 1'b1},
    {12'h001, 1'b0, 1'b0, 1'b1, 1'b0},
    {12'h555, 1'b1, 1'b1, 1'b0, 1'b0},
    {12'h7FE, 1'b1, 1'b0, 1'b0, 1'b0},
    {12'h000, 1'b0, 1'b1, 1'b1, 1'b1},
    {12'h800, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ion = 1'b0, iof = 1'b0, fgi = 1'b0, fgo = 1'b0, sc_clr = 1'b0, pc_ld = 1'b0;
  logic [AW-1:0] pc_d = '0;
  logic [2:0] t_o, fetch_o;
  logic r_o, ien_o, mem_we_o;
  logic [AW-1:0] pc_o, ar_o, tr_o, mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  intr_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .SC_W(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ion_i(ion), .iof_i(iof), .fgi_i(fgi), .fgo_i(fgo),
    .sc_clr_i(sc_clr), .pc_ld_i(pc_ld), .pc_d_i(pc_d), .t_o(t_o), .fetch_o(fetch_o),
    .r_o(r_o), .ien_o(ien_o), .pc_o(pc_o), .ar_o(ar_o), .tr_o(tr_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic [AW-1:0] p;
    p = v[15:4];
    @(negedge clk);
    pc_ld = 1'b1; pc_d = p; ion = v[1]; iof = !v[1]; sc_clr = 1'b1;
    @(negedge clk);
    pc_ld = 1'b0; ion = 1'b0; iof = 1'b0; sc_clr = 1'b0;
    chk("R8 pc load", 32'(pc_o), 32'(p));
    chk("R2 t0 after clear", 32'(t_o), 32'h1);
    fgi = v[3]; fgo = v[2];
    repeat (4) @(negedge clk);
    chk("R3 r set", 32'(r_o), 32'(v[0]));
    fgi = 1'b0; fgo = 1'b0; sc_clr = 1'b1;
    @(negedge clk);
    sc_clr = 1'b0;
    if (v[0]) begin
      chk("R9 fetch gated", 32'(fetch_o), 32'h0);
      @(negedge clk);
      chk("R4 ar", 32'(ar_o), 32'h0);
      chk("R4 tr", 32'(tr_o), 32'(p));
      chk("R5 we", 32'(mem_we_o), 32'h1);
      chk("R5 addr", 32'(mem_addr_o), 32'h0);
      chk("R5 wdata", 32'(mem_wdata_o), 32'(p));
      @(negedge clk);
      chk("R5 pc zero", 32'(pc_o), 32'h0);
      chk("R5 we single", 32'(mem_we_o), 32'h0);
      @(negedge clk);
      chk("R6 pc one", 32'(pc_o), 32'h1);
      chk("R6 r clr", 32'(r_o), 32'h0);
      chk("R6 ien clr", 32'(ien_o), 32'h0);
      chk("R6 sc clr", 32'(t_o), 32'h1);
    end else begin
      chk("R9 fetch t0", 32'(fetch_o), 32'h1);
      chk("R3 no write", 32'(mem_we_o), 32'h0);
      chk("R3 pc kept", 32'(pc_o), 32'(p));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic seen_r;
    repeat (3) @(negedge clk);
    chk("R1 r in reset", 32'(r_o), 32'h0);
    chk("R1 pc in reset", 32'(pc_o), 32'h0);
    rst_ni = 1'b1;
    chk("R1 t after reset", 32'(t_o), 32'h1);
    chk("R1 ien", 32'(ien_o), 32'h0);
    chk("R1 ar tr", 32'({ar_o, tr_o}), 32'h0);
    @(negedge clk); chk("R2 t1", 32'(t_o), 32'h2);
    @(negedge clk); chk("R2 t2", 32'(t_o), 32'h4);
    @(negedge clk); chk("R2 idle", 32'(t_o), 32'h0);

    // R7 enable set/clear priority
    ion = 1'b1; iof = 1'b1;
    @(negedge clk); chk("R7 iof wins", 32'(ien_o), 32'h0);
    iof = 1'b0;
    @(negedge clk); chk("R7 ion sets", 32'(ien_o), 32'h1);
    ion = 1'b0; iof = 1'b1;
    @(negedge clk); chk("R7 iof clears", 32'(ien_o), 32'h0);
    iof = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8 load ignored in cycle, R7 end clear beats ion, R6 flags ignored after
    @(negedge clk);
    pc_ld = 1'b1; pc_d = 12'h3A5; ion = 1'b1; sc_clr = 1'b1;
    @(negedge clk);
    pc_ld = 1'b0; ion = 1'b0; sc_clr = 1'b0; fgi = 1'b1; fgo = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 r set directed", 32'(r_o), 32'h1);
    pc_ld = 1'b1; pc_d = 12'h111;
    @(negedge clk);
    pc_ld = 1'b0;
    chk("R8 load ignored", 32'(pc_o), 32'h3A5);
    sc_clr = 1'b1;
    @(negedge clk); sc_clr = 1'b0;
    @(negedge clk);
    chk("R4 tr directed", 32'(tr_o), 32'h3A5);
    @(negedge clk);
    ion = 1'b1;
    @(negedge clk);
    ion = 1'b0;
    chk("R7 cycle end beats ion", 32'(ien_o), 32'h0);
    seen_r = 1'b0;
    repeat (12) begin @(negedge clk); seen_r |= r_o; end
    chk("R6 flags ignored", 32'(seen_r), 32'h0);
    ion = 1'b1;
    @(negedge clk);
    ion = 1'b0; fgi = 1'b0;
    seen_r = 1'b0;
    repeat (20) begin @(negedge clk); seen_r |= r_o; end
    fgo = 1'b0;
    chk("R3 r after re-enable", 32'(seen_r), 32'h1);
    repeat (12) @(negedge clk);
    chk("R6 pc after second cycle", 32'(pc_o), 32'h1);
    chk("R6 r idle", 32'(r_o), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule